// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block recovers characters from an NRZ serial line. The line is sampled on a 16x oversampling strobe. The strobe comes either from an internal rate pulse or from the rising edges of an external receive clock. Each character has one start bit, then 5 to 8 data bits sent least significant bit first. An optional parity bit may follow, and then a stop bit. The block detects the start of a character and checks that the start bit is still low at its centre. It then samples each following bit at its centre and stores the result in a receive data register, right-aligned.

A host reads the register by pulsing a read strobe. Four status outputs report the state of the register:
- receive-full
- overrun
- framing error
- parity error

The error flags are sticky. They clear only when an error-free character is loaded, and a load is only possible after the previous character has been read. A separate echo output can send the synchronized line back toward a transmitter. Characters are framed only while the terminal-ready control is set and the data-set-ready input is low.

Top module: `serial_rx16`

## Requirements
- R1: `cfg_word_len` selects the number of data bits: 00 = 8, 01 = 7, 10 = 6, 11 = 5. The first data bit received becomes bit 0 of `rd_data`. Bits above the word length read as 0, and the parity bit is never stored.
- R2: `cfg_parity` (bit 0 enables parity, bit 2 selects the unchecked form, bit 1 selects even) is decoded as follows:
  - x x 0: no parity bit.
  - 001: odd parity, checked.
  - 011: even parity, checked.
  - 101 and 111: a parity bit is received but never checked.
- R3: Each bit is sampled once. The start bit is sampled 8 strobes after the low line is seen, and every later bit 16 strobes after the previous sample. A start bit that samples high is discarded, and no character is produced.
- R4: A low first stop bit sets the framing error. The receiver then waits for the line to return high before it looks for a new start bit.
- R5: Loading a character sets `rx_full`. A one-cycle `rd_data_stb` clears it.
- R6: If a character completes while `rx_full` is set and no read occurs in that cycle, `err_overrun` is set and `rd_data` keeps the older character.
- R7: An error-free character that is loaded clears all three error flags. A loaded character that has errors adds its errors to flags that are already set.
- R8: Characters are received only while `cfg_term_ready` = 1 and `dsr_n` = 0. Otherwise the receiver stays idle.
- R9: With `cfg_echo` = 1, `echo_txd` equals `rxd` delayed by 3 clock cycles. With `cfg_echo` = 0 it stays high.
- R10: With `use_ext_clk` = 0 the strobe is `tick_int`. With `use_ext_clk` = 1 the strobe is each rising edge of `rxc_ext`, and `tick_int` is ignored.
- R11: After reset, `rd_data` is 0, all flags are 0 and `echo_txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_int | input | 1 | Internal 16x strobe, one cycle wide |
| rxc_ext | input | 1 | External 16x receive clock |
| use_ext_clk | input | 1 | 1 selects the external receive clock |
| rxd | input | 1 | Serial input line |
| cfg_word_len | input | 2 | Data bit count code |
| cfg_parity | input | 3 | Parity mode code |
| cfg_echo | input | 1 | Echo enable |
| cfg_term_ready | input | 1 | Receiver enable (terminal ready) |
| dsr_n | input | 1 | Data set ready, active low |
| rd_data_stb | input | 1 | Read of the receive data register |
| rd_data | output | 8 | Receive data register |
| rx_full | output | 1 | Receive register holds unread data |
| err_overrun | output | 1 | Overrun flag |
| err_framing | output | 1 | Framing error flag |
| err_parity | output | 1 | Parity error flag |
| echo_txd | output | 1 | Echoed serial output |

## Verification
The directed tests check several behaviours against each other:
- 8-bit and 5-bit characters show whether data is right-aligned and zero-filled.
- A short low glitch separates a real start from a false one.
- Two characters with no read between them separate an overrun from a normal load.
- A deliberately flipped parity bit separates the checked parity modes from the unchecked ones.
- A frozen external clock shows that the strobe source select really ignores the internal pulse.

Random characters then mix word lengths, parity modes, injected parity and stop-bit errors, skipped reads and both strobe sources. Each random character is checked against a bench model of the sticky flag rules.

// File: rtl/rxo_pkg.sv
package rxo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD
  } rx_state_e;

  typedef enum logic [1:0] {
    PM_NONE,
    PM_ODD,
    PM_EVEN,
    PM_NOCHK
  } par_mode_e;

  // bit0 enables parity, bit2 selects the unchecked form, bit1 selects even
  function automatic par_mode_e decode_par(input logic [2:0] code);
    if (!code[0])     return PM_NONE;
    else if (code[2]) return PM_NOCHK;
    else if (code[1]) return PM_EVEN;
    else              return PM_ODD;
  endfunction

endpackage

// File: rtl/rxo_sync.sv
module rxo_sync #(
  parameter int STAGES = 2,
  parameter bit INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= {STAGES{INIT}};
    end else begin
      sr[0] <= d;
      for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
    end
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/rxo_tick_sel.sv
module rxo_tick_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic use_ext,
  input  logic int_tick,
  input  logic ext_clk,
  output logic tick
);
  logic ext_s;
  logic ext_d;

  rxo_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_ext_sync (
    .clk (clk),
    .rst (rst),
    .d   (ext_clk),
    .q   (ext_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_d <= 1'b0;
      tick  <= 1'b0;
    end else begin
      ext_d <= ext_s;
      tick  <= use_ext ? (ext_s & ~ext_d) : int_tick;
    end
  end

  // R10: with the external source selected and its clock held, no strobe
  assert_ext_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (use_ext && $stable(ext_s) && $stable(ext_d)) |=> !tick);
endmodule

// File: rtl/rxo_frame.sv
module rxo_frame
  import rxo_pkg::*;
#(
  parameter int W         = 8,
  parameter int OVS       = 16,
  parameter int SAMPLE_AT = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         tick,
  input  logic         rxd,
  input  logic [1:0]   word_code,
  input  logic [2:0]   par_code,
  output logic         done,
  output logic [W-1:0] data_out,
  output logic         fe_out,
  output logic         pe_out
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(SAMPLE_AT - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

  rx_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] bit_i;
  logic [IDX_W-1:0] nb_q;
  par_mode_e        pm_q;
  logic [W-1:0]     shreg;
  logic             par_acc;
  logic             par_bit;
  logic             par_bad;

  always_comb begin
    par_bad = 1'b0;
    case (pm_q)
      PM_ODD:  par_bad = ~(par_acc ^ par_bit);
      PM_EVEN: par_bad =  (par_acc ^ par_bit);
      default: par_bad = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst || !en) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bit_i    <= '0;
      nb_q     <= IDX_W'(W);
      pm_q     <= PM_NONE;
      shreg    <= '0;
      par_acc  <= 1'b0;
      par_bit  <= 1'b0;
      data_out <= '0;
      fe_out   <= 1'b0;
      pe_out   <= 1'b0;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (!rxd) begin
            state <= ST_START;
            nb_q  <= IDX_W'(W) - IDX_W'(word_code);
            pm_q  <= decode_par(par_code);
          end
        end
        ST_START: begin
          if (cnt == MID) begin
            cnt     <= '0;
            bit_i   <= '0;
            shreg   <= '0;
            par_acc <= 1'b0;
            state   <= rxd ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt == LAST) begin
            cnt     <= '0;
            shreg   <= {rxd, shreg[W-1:1]};
            par_acc <= par_acc ^ rxd;
            if (bit_i == nb_q - 1'b1) begin
              state <= (pm_q == PM_NONE) ? ST_STOP : ST_PAR;
            end else begin
              bit_i <= bit_i + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (cnt == LAST) begin
            cnt     <= '0;
            par_bit <= rxd;
            state   <= ST_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt == LAST) begin
            cnt      <= '0;
            done     <= 1'b1;
            data_out <= shreg >> (IDX_W'(W) - nb_q);
            fe_out   <= ~rxd;
            pe_out   <= par_bad;
            state    <= rxd ? ST_IDLE : ST_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HOLD: begin
          cnt <= '0;
          if (rxd) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: bits above the word length are zero when a character is delivered
  assert_zero_fill_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> ((data_out >> nb_q) == '0));

  // R2: unchecked or absent parity never reports an error
  assert_nochk_R2: assert property (@(posedge clk) disable iff (rst)
    (done && (pm_q == PM_NONE || pm_q == PM_NOCHK)) |-> !pe_out);

  // R8: a disabled receiver delivers nothing
  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> !done);
endmodule

// File: rtl/rxo_status.sv
module rxo_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] in_data,
  input  logic         in_fe,
  input  logic         in_pe,
  input  logic         rd_stb,
  output logic [W-1:0] data,
  output logic         full,
  output logic         ovr,
  output logic         fe,
  output logic         pe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      full <= 1'b0;
      ovr  <= 1'b0;
      fe   <= 1'b0;
      pe   <= 1'b0;
    end else if (load && full && !rd_stb) begin
      ovr <= 1'b1;
    end else if (load) begin
      data <= in_data;
      full <= 1'b1;
      if (!in_fe && !in_pe) begin
        ovr <= 1'b0;
        fe  <= 1'b0;
        pe  <= 1'b0;
      end else begin
        fe <= fe | in_fe;
        pe <= pe | in_pe;
      end
    end else if (rd_stb) begin
      full <= 1'b0;
    end
  end

  // R6: a completed character on a full register raises overrun, data kept
  assert_overrun_keep_R6: assert property (@(posedge clk) disable iff (rst)
    (load && full && !rd_stb) |=> (ovr && $stable(data)));

  // R5: a read with no load empties the register
  assert_read_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !load) |=> !full);

  // R5: any load leaves the register full
  assert_load_full_R5: assert property (@(posedge clk) disable iff (rst)
    load |=> full);

  // R7: an error flag survives any cycle without a load
  assert_sticky_fe_R7: assert property (@(posedge clk) disable iff (rst)
    (fe && !load) |=> fe);
endmodule

// File: rtl/serial_rx16.sv
module serial_rx16 #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SAMPLE_AT   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_int,
  input  logic              rxc_ext,
  input  logic              use_ext_clk,
  input  logic              rxd,
  input  logic [1:0]        cfg_word_len,
  input  logic [2:0]        cfg_parity,
  input  logic              cfg_echo,
  input  logic              cfg_term_ready,
  input  logic              dsr_n,
  input  logic              rd_data_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_full,
  output logic              err_overrun,
  output logic              err_framing,
  output logic              err_parity,
  output logic              echo_txd
);
  logic              tick;
  logic              rxd_s;
  logic              rx_en;
  logic              f_done;
  logic [DATA_W-1:0] f_data;
  logic              f_fe;
  logic              f_pe;

  assign rx_en = cfg_term_ready & ~dsr_n;

  rxo_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .use_ext  (use_ext_clk),
    .int_tick (tick_int),
    .ext_clk  (rxc_ext),
    .tick     (tick)
  );

  rxo_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_rxd_sync (
    .clk (clk),
    .rst (rst),
    .d   (rxd),
    .q   (rxd_s)
  );

  rxo_frame #(.W(DATA_W), .OVS(OVS), .SAMPLE_AT(SAMPLE_AT)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .en        (rx_en),
    .tick      (tick),
    .rxd       (rxd_s),
    .word_code (cfg_word_len),
    .par_code  (cfg_parity),
    .done      (f_done),
    .data_out  (f_data),
    .fe_out    (f_fe),
    .pe_out    (f_pe)
  );

  rxo_status #(.W(DATA_W)) u_status (
    .clk     (clk),
    .rst     (rst),
    .load    (f_done),
    .in_data (f_data),
    .in_fe   (f_fe),
    .in_pe   (f_pe),
    .rd_stb  (rd_data_stb),
    .data    (rd_data),
    .full    (rx_full),
    .ovr     (err_overrun),
    .fe      (err_framing),
    .pe      (err_parity)
  );

  always_ff @(posedge clk) begin
    if (rst) echo_txd <= 1'b1;
    else     echo_txd <= cfg_echo ? rxd_s : 1'b1;
  end

  // R9: echo disabled holds the output at mark
  assert_echo_mark_R9: assert property (@(posedge clk) disable iff (rst)
    !cfg_echo |=> echo_txd);
endmodule

// File: tb/serial_rx16_tb.sv
module serial_rx16_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_int = 1'b0;
  logic       rxc_ext = 1'b0;
  logic       ext_run = 1'b1;
  logic       use_ext_clk = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] cfg_word_len = 2'b00;
  logic [2:0] cfg_parity = 3'b000;
  logic       cfg_echo = 1'b0;
  logic       cfg_term_ready = 1'b1;
  logic       dsr_n = 1'b0;
  logic       rd_data_stb = 1'b0;
  logic [7:0] rd_data;
  logic       rx_full, err_overrun, err_framing, err_parity, echo_txd;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [1:0] div = 2'd0;

  logic [7:0] m_data = 8'h00;
  logic       m_full = 0, m_ovr = 0, m_fe = 0, m_pe = 0;

  serial_rx16 u_dut (
    .clk(clk), .rst(rst), .tick_int(tick_int), .rxc_ext(rxc_ext),
    .use_ext_clk(use_ext_clk), .rxd(rxd), .cfg_word_len(cfg_word_len),
    .cfg_parity(cfg_parity), .cfg_echo(cfg_echo),
    .cfg_term_ready(cfg_term_ready), .dsr_n(dsr_n),
    .rd_data_stb(rd_data_stb), .rd_data(rd_data), .rx_full(rx_full),
    .err_overrun(err_overrun), .err_framing(err_framing),
    .err_parity(err_parity), .echo_txd(echo_txd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    div      <= div + 2'd1;
    tick_int <= (div == 2'(TICK_DIV - 1));
    rxc_ext  <= ext_run ? div[1] : 1'b0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nbits(input logic [1:0] wl);
    return 8 - int'(wl);
  endfunction

  function automatic logic [7:0] mask_of(input logic [1:0] wl);
    return 8'hFF >> wl;
  endfunction

  // parity bit a correct sender puts on the line
  function automatic logic good_par(input logic [7:0] d, input logic [1:0] wl, input logic [2:0] pc);
    logic p;
    p = ^(d & mask_of(wl));
    if (pc == 3'b001) return ~p;
    if (pc == 3'b011) return p;
    return 1'b0;
  endfunction

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk) rd_data_stb = 1'b1;
    @(negedge clk) rd_data_stb = 1'b0;
    m_full = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic flip, input logic stop_v);
    logic pb;
    @(negedge clk) rxd = 1'b0;
    wait_clks(BIT_CLKS);
    for (int i = 0; i < nbits(cfg_word_len); i++) begin
      rxd = d[i];
      wait_clks(BIT_CLKS);
    end
    if (cfg_parity[0]) begin
      pb = (cfg_parity[2]) ? 1'($urandom % 2) : good_par(d, cfg_word_len, cfg_parity);
      rxd = pb ^ flip;
      wait_clks(BIT_CLKS);
    end
    rxd = stop_v;
    wait_clks(BIT_CLKS);
    rxd = 1'b1;
    wait_clks(48);
  endtask

  // send one character and update the model from the requirements
  task automatic send_model(input logic [7:0] d, input logic flip, input logic stop_v);
    logic pe_e, fe_e;
    send_frame(d, flip, stop_v);
    pe_e = flip && (cfg_parity == 3'b001 || cfg_parity == 3'b011);
    fe_e = !stop_v;
    if (m_full) begin
      m_ovr = 1'b1;
    end else begin
      m_data = d & mask_of(cfg_word_len);
      m_full = 1'b1;
      if (!pe_e && !fe_e) begin
        m_ovr = 0; m_fe = 0; m_pe = 0;
      end else begin
        m_fe = m_fe | fe_e;
        m_pe = m_pe | pe_e;
      end
    end
  endtask

  task automatic check_model(input string req);
    chk({req, " data"},    32'(rd_data),     32'(m_data));
    chk({req, " full"},    32'(rx_full),     32'(m_full));
    chk({req, " overrun"}, 32'(err_overrun), 32'(m_ovr));
    chk({req, " framing"}, 32'(err_framing), 32'(m_fe));
    chk({req, " parity"},  32'(err_parity),  32'(m_pe));
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog R5 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2741));
    wait_clks(5);
    rst = 1'b0;
    wait_clks(2);
    // R11 reset state
    chk("R11 data", 32'(rd_data), 32'h0);
    chk("R11 flags", {28'd0, rx_full, err_overrun, err_framing, err_parity}, 32'h0);
    chk("R11 echo", 32'(echo_txd), 32'h1);

    // R1/R5 basic 8-bit no parity
    send_model(8'hA5, 1'b0, 1'b1);
    check_model("R1 8bit");
    do_read();
    wait_clks(2);
    chk("R5 read clears full", 32'(rx_full), 32'h0);

    // R1 5-bit word, high bits zero
    cfg_word_len = 2'b11;
    send_model(8'hFF, 1'b0, 1'b1);
    chk("R1 5bit zero fill", 32'(rd_data), 32'h1F);
    do_read();
    cfg_word_len = 2'b01;
    send_model(8'hC3, 1'b0, 1'b1);
    chk("R1 7bit", 32'(rd_data), 32'h43);
    do_read();
    cfg_word_len = 2'b00;

    // R3 false start: short low glitch
    @(negedge clk) rxd = 1'b0;
    wait_clks(12);
    rxd = 1'b1;
    wait_clks(200);
    chk("R3 false start no frame", 32'(rx_full), 32'h0);
    send_model(8'h3C, 1'b0, 1'b1);
    check_model("R3 after glitch");

    // R6 overrun: no read between two characters
    send_model(8'h77, 1'b0, 1'b1);
    chk("R6 overrun set", 32'(err_overrun), 32'h1);
    chk("R6 old data kept", 32'(rd_data), 32'h3C);
    do_read();
    send_model(8'h11, 1'b0, 1'b1);
    chk("R7 clean frame clears overrun", 32'(err_overrun), 32'h0);
    do_read();

    // R4 framing error, then R7 clear
    send_model(8'h5A, 1'b0, 1'b0);
    chk("R4 framing set", 32'(err_framing), 32'h1);
    do_read();
    cfg_parity = 3'b001;
    send_model(8'h0F, 1'b1, 1'b1);
    chk("R7 framing sticky on errored frame", 32'(err_framing), 32'h1);
    chk("R2 odd parity error", 32'(err_parity), 32'h1);
    do_read();
    send_model(8'h0F, 1'b0, 1'b1);
    check_model("R7 clean frame clears");
    chk("R2 parity not stored", 32'(rd_data), 32'h0F);
    do_read();

    // R2 even and unchecked modes
    cfg_parity = 3'b011;
    send_model(8'h81, 1'b1, 1'b1);
    chk("R2 even parity error", 32'(err_parity), 32'h1);
    do_read();
    cfg_parity = 3'b101;
    send_model(8'h81, 1'b1, 1'b1);
    chk("R2 unchecked parity clean", 32'(err_parity), 32'h0);
    check_model("R2 unchecked");
    do_read();
    cfg_parity = 3'b000;

    // R8 receiver disabled
    cfg_term_ready = 1'b0;
    send_frame(8'h99, 1'b0, 1'b1);
    chk("R8 terminal not ready", 32'(rx_full), 32'h0);
    cfg_term_ready = 1'b1;
    dsr_n = 1'b1;
    send_frame(8'h99, 1'b0, 1'b1);
    chk("R8 data set not ready", 32'(rx_full), 32'h0);
    dsr_n = 1'b0;

    // R10 external clock source
    use_ext_clk = 1'b1;
    ext_run = 1'b0;
    send_frame(8'h66, 1'b0, 1'b1);
    chk("R10 internal tick ignored", 32'(rx_full), 32'h0);
    ext_run = 1'b1;
    send_model(8'h66, 1'b0, 1'b1);
    check_model("R10 external clock");
    do_read();
    use_ext_clk = 1'b0;

    // R9 echo, receiver disabled so the line levels frame nothing
    cfg_term_ready = 1'b0;
    cfg_echo = 1'b1;
    @(negedge clk) rxd = 1'b0;
    wait_clks(6);
    chk("R9 echo low", 32'(echo_txd), 32'h0);
    rxd = 1'b1;
    wait_clks(6);
    chk("R9 echo high", 32'(echo_txd), 32'h1);
    rxd = 1'b0;
    wait_clks(3);
    chk("R9 echo delay 3", 32'(echo_txd), 32'h0);
    cfg_echo = 1'b0;
    wait_clks(6);
    chk("R9 echo off mark", 32'(echo_txd), 32'h1);
    rxd = 1'b1;
    wait_clks(6);
    cfg_term_ready = 1'b1;

    // random characters
    for (int n = 0; n < 28; n++) begin
      logic [7:0] d;
      logic flip, stop_v;
      if (m_full && ($urandom % 5 != 0)) do_read();
      cfg_word_len = 2'($urandom % 4);
      case ($urandom % 6)
        0: cfg_parity = 3'b000;
        1: cfg_parity = 3'b001;
        2: cfg_parity = 3'b011;
        3: cfg_parity = 3'b101;
        4: cfg_parity = 3'b111;
        default: cfg_parity = 3'b010;
      endcase
      use_ext_clk = 1'($urandom % 2);
      d = 8'($urandom);
      flip = ($urandom % 5 == 0);
      stop_v = ($urandom % 6 != 0);
      send_model(d, flip, stop_v);
      check_model("R7 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule